// File: doc/BRIEF.md
# Pin Trigger and EOI Tracker

This block holds the per-pin request state of a 24-input interrupt router. Each cycle it takes the raw level of every input pin and that pin's settings: an inversion bit, a trigger type (edge or level), a mask bit and an 8-bit vector. It keeps one request bit and one remote-in-service flag per pin. From these it decides which pins need service and queues them. It then offers one delivery request at a time, carrying the pin index, over a valid/ready handshake.

When an assertion of a pin cannot be serviced, the block reports it as a coalesced interrupt with a one-cycle pulse carrying the pin index. An end-of-interrupt (EOI) broadcast carries a vector and a type bit. Every pin programmed with that vector gets an acknowledge pulse. A level-type EOI also frees matching level-triggered pins, and any such pin that is still asserted is serviced again. Register access, message formatting and destination selection sit in neighbouring blocks. The one exception is that deliveries from pin 0 carry a flag that sends them to the boot processor in physical mode.

Top module: `pin_trig_eoi_tracker`

## Requirements
- R1: A pin's effective level is its input level XOR its `cfg_invert_i` bit, and its request bit follows the effective level one cycle later. A 0-to-1 change of the effective level counts as an assertion, whatever the raw input did.
- R2: For an edge-triggered pin (`cfg_level_trig_i`=0), an unmasked assertion gives exactly one delivery whose `dlv_pin_o` equals the pin index, provided the pin has no request queued or in flight. A de-assertion gives no delivery.
- R3: A level-triggered pin (`cfg_level_trig_i`=1) is delivered on assertion only while its remote-in-service flag is clear. The flag is set by the handshake (`dlv_valid_o` and `dlv_ready_i` both high) that delivers that pin.
- R4: An assertion on a pin that already has a request queued or in flight, or on a level pin whose remote-in-service flag is set, gives no delivery. Instead it gives one `coal_pulse_o` cycle with `coal_pin_o` equal to the pin index.
- R5: An assertion of a masked pin (`cfg_mask_i`=1) with nothing queued gives neither a delivery nor a coalesced pulse. Re-service after an EOI or a rewrite is also suppressed while the pin is masked.
- R6: An EOI (`eoi_valid_i` high for one cycle) gives one `ack_pulse_o` cycle for every pin whose vector equals `eoi_vector_i`. The pulses come in consecutive cycles, in ascending pin order, with the index on `ack_pin_o`.
- R7: A level-type EOI (`eoi_level_i`=1) clears the remote-in-service flag of each matching level pin. If that pin is unmasked and its request bit is still set, it is delivered again. An edge-type EOI (`eoi_level_i`=0) clears nothing and causes no delivery.
- R8: A one-cycle pulse on `cfg_rewrite_i[p]` clears pin p's remote-in-service flag. If p is level-triggered, unmasked and still requesting, it is delivered again.
- R9: Pins that need service at the same time are delivered one per handshake, lowest index first. While `dlv_ready_i` is low, `dlv_valid_o` stays high and `dlv_pin_o` holds its value.
- R10: `dlv_to_boot_o` is 1 while a delivery for pin 0 is offered, and 0 for every other pin.
- R11: While reset is applied and after it is released with no input activity, `dlv_valid_o`, `coal_pulse_o` and `ack_pulse_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| pin_level_i | input | 24 | Raw input pin levels |
| cfg_invert_i | input | 24 | Per-pin polarity inversion |
| cfg_level_trig_i | input | 24 | Per-pin trigger type, 1 = level, 0 = edge |
| cfg_mask_i | input | 24 | Per-pin mask |
| cfg_vector_i | input | 192 | Per-pin vector; pin p occupies bits 8p+7..8p |
| cfg_rewrite_i | input | 24 | One-cycle pulse per pin: the pin's entry was rewritten |
| eoi_valid_i | input | 1 | EOI broadcast strobe |
| eoi_vector_i | input | 8 | Vector carried by the EOI |
| eoi_level_i | input | 1 | EOI type, 1 = level |
| dlv_valid_o | output | 1 | Delivery request valid |
| dlv_ready_i | input | 1 | Delivery request accepted |
| dlv_pin_o | output | 5 | Pin index of the delivery |
| dlv_to_boot_o | output | 1 | Delivery must go to the boot processor in physical mode |
| coal_pulse_o | output | 1 | Coalesced interrupt pulse |
| coal_pin_o | output | 5 | Pin index of the coalesced interrupt |
| ack_pulse_o | output | 1 | EOI acknowledge pulse |
| ack_pin_o | output | 5 | Pin index being acknowledged |

## Verification
The bench sweeps an assertion across every pin. A wrong index encode or a missing boot flag on pin 0 would show up there as a misnumbered delivery. It asserts several pins while the receiver stalls, to catch a queue that loses requests, reorders them or lets the offered index drift during a stall. It drives a level pin through coalescing, an edge-type EOI, a level-type EOI with the pin still high, a masked EOI and an entry rewrite. A design that released on the wrong EOI type, ignored the mask on re-service, or forgot the remote-in-service flag would deliver too often or not at all. A shared-vector EOI checks that every matching pin is acknowledged in consecutive cycles in ascending order.

// File: rtl/ptet_pkg.sv
package ptet_pkg;
   localparam int unsigned PTET_PINS_DEF  = 24;
   localparam int unsigned PTET_VEC_W_DEF = 8;

   function automatic int unsigned idx_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/ptet_lowest_pick.sv
module ptet_lowest_pick #(
   parameter int unsigned N  = 24,
   parameter int unsigned IW = 5
) (
   input  logic [N-1:0]  req_i,
   output logic          any_o,
   output logic [IW-1:0] idx_o,
   output logic [N-1:0]  onehot_o
);
   always_comb begin
      idx_o    = '0;
      onehot_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            idx_o       = IW'(i);
            onehot_o    = '0;
            onehot_o[i] = 1'b1;
         end
      end
   end
   assign any_o = |req_i;
endmodule

// File: rtl/ptet_pulse_queue.sv
module ptet_pulse_queue #(
   parameter int unsigned N  = 24,
   parameter int unsigned IW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  set_i,
   output logic          pulse_o,
   output logic [IW-1:0] pin_o
);
   logic [N-1:0]  pend_q, pick_oh;
   logic          pick_any;
   logic [IW-1:0] pick_idx;

   ptet_lowest_pick #(.N(N), .IW(IW)) u_pick (
      .req_i(pend_q), .any_o(pick_any), .idx_o(pick_idx), .onehot_o(pick_oh)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q  <= '0;
         pulse_o <= 1'b0;
         pin_o   <= '0;
      end else begin
         pend_q  <= (pend_q & ~pick_oh) | set_i;
         pulse_o <= pick_any;
         pin_o   <= pick_idx;
      end
   end

   // R4 and R6: a pulse always names an existing pin
   a_r6_pulse_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |-> (int'(pin_o) < int'(N)));
endmodule

// File: rtl/pin_trig_eoi_tracker.sv
module pin_trig_eoi_tracker #(
   parameter int unsigned NUM_PINS      = ptet_pkg::PTET_PINS_DEF,
   parameter int unsigned VEC_W         = ptet_pkg::PTET_VEC_W_DEF,
   parameter bit          BOOT_STEER_EN = 1'b1,
   localparam int unsigned IW           = ptet_pkg::idx_w(NUM_PINS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_PINS-1:0]       pin_level_i,
   input  logic [NUM_PINS-1:0]       cfg_invert_i,
   input  logic [NUM_PINS-1:0]       cfg_level_trig_i,
   input  logic [NUM_PINS-1:0]       cfg_mask_i,
   input  logic [NUM_PINS*VEC_W-1:0] cfg_vector_i,
   input  logic [NUM_PINS-1:0]       cfg_rewrite_i,
   input  logic                      eoi_valid_i,
   input  logic [VEC_W-1:0]          eoi_vector_i,
   input  logic                      eoi_level_i,
   output logic                      dlv_valid_o,
   input  logic                      dlv_ready_i,
   output logic [IW-1:0]             dlv_pin_o,
   output logic                      dlv_to_boot_o,
   output logic                      coal_pulse_o,
   output logic [IW-1:0]             coal_pin_o,
   output logic                      ack_pulse_o,
   output logic [IW-1:0]             ack_pin_o
);
   localparam int unsigned N = NUM_PINS;

   if (N < 1 || (1 << IW) < N) begin : g_bad_pins
      $error("pin_trig_eoi_tracker: NUM_PINS out of range");
   end
   if (VEC_W < 1) begin : g_bad_vec
      $error("pin_trig_eoi_tracker: VEC_W must be at least 1");
   end

   logic [N-1:0]  req_q, rirr_q, pend_q;
   logic [N-1:0]  eff, rise, in_flight, busy, eoi_hit, release_p;
   logic [N-1:0]  want, coal_set, deliver_lvl, pick_oh;
   logic          dlv_valid_q, dlv_lvl_q, slot_free, pick_any;
   logic [IW-1:0] dlv_pin_q, pick_idx;

   assign eff       = pin_level_i ^ cfg_invert_i;
   assign rise      = eff & ~req_q;
   assign slot_free = ~dlv_valid_q | dlv_ready_i;

   for (genvar p = 0; p < N; p++) begin : g_pin
      logic lvl, rise_svc, resvc;
      assign lvl            = cfg_level_trig_i[p];
      assign in_flight[p]   = dlv_valid_q && (dlv_pin_q == IW'(p));
      assign busy[p]        = pend_q[p] | in_flight[p];
      assign eoi_hit[p]     = eoi_valid_i && (cfg_vector_i[p*VEC_W +: VEC_W] == eoi_vector_i);
      assign release_p[p]   = (eoi_hit[p] & eoi_level_i & lvl) | cfg_rewrite_i[p];
      assign deliver_lvl[p] = in_flight[p] & dlv_ready_i & dlv_lvl_q;
      assign rise_svc       = rise[p] & ~busy[p] & (~lvl | ~rirr_q[p]);
      assign resvc          = release_p[p] & lvl & req_q[p] & ~busy[p];
      assign want[p]        = (rise_svc | resvc) & ~cfg_mask_i[p];
      assign coal_set[p]    = rise[p] & (busy[p] | (lvl & rirr_q[p]));

      // R3: the flag only rises on a handshake for this pin
      a_r3_rirr_from_delivery: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(rirr_q[p]) |-> $past(dlv_valid_q && dlv_ready_i && dlv_pin_q == IW'(p)));
      // R7 and R8: the flag only falls on a level-type EOI or a rewrite
      a_r7_rirr_release: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(rirr_q[p]) |-> $past((eoi_valid_i && eoi_level_i) || cfg_rewrite_i[p]));
   end

   ptet_lowest_pick #(.N(N), .IW(IW)) u_dlv_pick (
      .req_i(pend_q), .any_o(pick_any), .idx_o(pick_idx), .onehot_o(pick_oh)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q       <= '0;
         rirr_q      <= '0;
         pend_q      <= '0;
         dlv_valid_q <= 1'b0;
         dlv_pin_q   <= '0;
         dlv_lvl_q   <= 1'b0;
      end else begin
         req_q  <= eff;
         rirr_q <= (rirr_q & ~release_p) | deliver_lvl;
         pend_q <= (pend_q & ~(pick_oh & {N{slot_free}})) | want;
         if (slot_free) begin
            dlv_valid_q <= pick_any;
            if (pick_any) begin
               dlv_pin_q <= pick_idx;
               dlv_lvl_q <= cfg_level_trig_i[pick_idx];
            end
         end
      end
   end

   assign dlv_valid_o = dlv_valid_q;
   assign dlv_pin_o   = dlv_pin_q;

   if (BOOT_STEER_EN) begin : g_boot_steer
      assign dlv_to_boot_o = dlv_valid_q && (dlv_pin_q == '0);
   end else begin : g_no_boot_steer
      assign dlv_to_boot_o = 1'b0;
   end

   ptet_pulse_queue #(.N(N), .IW(IW)) u_coal_q (
      .clk(clk), .rst_n(rst_n), .set_i(coal_set), .pulse_o(coal_pulse_o), .pin_o(coal_pin_o)
   );
   ptet_pulse_queue #(.N(N), .IW(IW)) u_ack_q (
      .clk(clk), .rst_n(rst_n), .set_i(eoi_hit), .pulse_o(ack_pulse_o), .pin_o(ack_pin_o)
   );

   // R9: an offered delivery is held until it is taken
   a_r9_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (dlv_valid_o && !dlv_ready_i) |=> (dlv_valid_o && $stable(dlv_pin_o)));
   // R9: the pin in flight is never queued a second time
   a_r9_no_duplicate: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_valid_q |-> !pend_q[dlv_pin_q]);
endmodule

// File: tb/pin_trig_eoi_tracker_tb.sv
module pin_trig_eoi_tracker_tb_top;
   localparam int N  = 24;
   localparam int VW = 8;
   localparam int IW = 5;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic              rst_n;
   logic [N-1:0]      level, inv, trig, mask, rewrite;
   logic [VW-1:0]     vec [N];
   logic [N*VW-1:0]   vec_flat;
   logic              eoi_v, eoi_l, dlv_ready;
   logic [VW-1:0]     eoi_vec;
   logic              dlv_valid, dlv_boot, coal_p, ack_p;
   logic [IW-1:0]     dlv_pin, coal_pin, ack_pin;

   always_comb for (int i = 0; i < N; i++) vec_flat[i*VW +: VW] = vec[i];

   pin_trig_eoi_tracker dut_i (
      .clk(clk), .rst_n(rst_n), .pin_level_i(level), .cfg_invert_i(inv),
      .cfg_level_trig_i(trig), .cfg_mask_i(mask), .cfg_vector_i(vec_flat),
      .cfg_rewrite_i(rewrite), .eoi_valid_i(eoi_v), .eoi_vector_i(eoi_vec),
      .eoi_level_i(eoi_l), .dlv_valid_o(dlv_valid), .dlv_ready_i(dlv_ready),
      .dlv_pin_o(dlv_pin), .dlv_to_boot_o(dlv_boot), .coal_pulse_o(coal_p),
      .coal_pin_o(coal_pin), .ack_pulse_o(ack_p), .ack_pin_o(ack_pin)
   );

   int n_checks = 0, n_err = 0, cyc = 0;
   int dlv_n = 0, ack_n = 0;
   int dlv_log [1024];
   bit boot_log [1024];
   int ack_log [1024];
   int ack_cyc [1024];
   int coal_cnt [N] = '{default: 0};

   always @(posedge clk) begin
      cyc++;
      if (rst_n) begin
         if (dlv_valid && dlv_ready && dlv_n < 1024) begin
            dlv_log[dlv_n] = int'(dlv_pin); boot_log[dlv_n] = dlv_boot; dlv_n++;
         end
         if (ack_p && ack_n < 1024) begin
            ack_log[ack_n] = int'(ack_pin); ack_cyc[ack_n] = cyc; ack_n++;
         end
         if (coal_p && int'(coal_pin) < N) coal_cnt[coal_pin]++;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_up();
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   endtask

   task automatic send_eoi(input logic [VW-1:0] v, input logic lvl);
      eoi_vec = v; eoi_l = lvl; eoi_v = 1'b1;
      wait_n(1);
      eoi_v = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++; n_err++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      finish_up();
   end

   initial begin
      int d0, a0, c0;
      rst_n = 1'b0; level = '0; inv = '0; trig = '0; mask = '0; rewrite = '0;
      eoi_v = 1'b0; eoi_l = 1'b0; eoi_vec = '0; dlv_ready = 1'b1;
      for (int i = 0; i < N; i++) vec[i] = VW'(8'h20 + i);
      wait_n(3);
      // R11 reset state
      chk(!dlv_valid && !coal_p && !ack_p, "R11 outputs in reset", int'(dlv_valid), 0);
      rst_n = 1'b1;
      wait_n(6);
      chk(dlv_n == 0 && ack_n == 0 && !dlv_valid, "R11 idle after reset", dlv_n, 0);

      // R2 / R10 edge sweep over every pin
      for (int p = 0; p < N; p++) begin
         d0 = dlv_n;
         level[p] = 1'b1; wait_n(6);
         chk(dlv_n == d0 + 1 && dlv_log[d0] == p, "R2 edge delivery pin index", dlv_log[d0], p);
         chk(boot_log[d0] == (p == 0), "R10 boot steering flag", int'(boot_log[d0]), int'(p == 0));
         level[p] = 1'b0; wait_n(4);
         chk(dlv_n == d0 + 1, "R2 no delivery on de-assertion", dlv_n, d0 + 1);
      end

      // R1 polarity on pin 5
      d0 = dlv_n;
      inv[5] = 1'b1; wait_n(8);
      chk(dlv_n == d0 + 1 && dlv_log[d0] == 5, "R1 inverted low level asserts", dlv_n, d0 + 1);
      level[5] = 1'b1; wait_n(8);
      chk(dlv_n == d0 + 1, "R1 inverted high level is idle", dlv_n, d0 + 1);
      level[5] = 1'b0; wait_n(8);
      chk(dlv_n == d0 + 2, "R1 inverted falling input asserts", dlv_n, d0 + 2);
      inv[5] = 1'b0; wait_n(4);

      // R5 masked idle pin
      d0 = dlv_n;
      mask[7] = 1'b1; level[7] = 1'b1; wait_n(8);
      chk(dlv_n == d0, "R5 masked pin not delivered", dlv_n, d0);
      chk(coal_cnt[7] == 0, "R5 masked pin not coalesced", coal_cnt[7], 0);
      level[7] = 1'b0; wait_n(3); mask[7] = 1'b0; wait_n(2);

      // R9 ordering and hold under stall
      d0 = dlv_n; dlv_ready = 1'b0;
      level[9] = 1'b1; level[3] = 1'b1; level[15] = 1'b1; wait_n(6);
      chk(dlv_valid && dlv_pin == 3, "R9 lowest pin offered first", int'(dlv_pin), 3);
      wait_n(5);
      chk(dlv_valid && dlv_pin == 3, "R9 offer held while stalled", int'(dlv_pin), 3);
      dlv_ready = 1'b1; wait_n(8);
      chk(dlv_n == d0 + 3, "R9 all queued pins delivered", dlv_n, d0 + 3);
      chk(dlv_log[d0] == 3 && dlv_log[d0+1] == 9 && dlv_log[d0+2] == 15,
          "R9 ascending delivery order", dlv_log[d0+1], 9);
      level[9] = 1'b0; level[3] = 1'b0; level[15] = 1'b0; wait_n(4);

      // R4 edge coalescing while in flight
      d0 = dlv_n; dlv_ready = 1'b0;
      level[4] = 1'b1; wait_n(4); level[4] = 1'b0; wait_n(2); level[4] = 1'b1; wait_n(6);
      chk(coal_cnt[4] == 1, "R4 edge re-assert while in flight coalesced", coal_cnt[4], 1);
      dlv_ready = 1'b1; wait_n(8);
      chk(dlv_n == d0 + 1, "R4 coalesced assert not delivered", dlv_n, d0 + 1);
      level[4] = 1'b0; wait_n(4);

      // R3 / R7 / R5 / R8 level pin 10
      trig[10] = 1'b1; vec[10] = 8'h40; wait_n(2);
      d0 = dlv_n;
      level[10] = 1'b1; wait_n(8);
      chk(dlv_n == d0 + 1 && dlv_log[d0] == 10, "R3 level pin delivered", dlv_n, d0 + 1);
      c0 = coal_cnt[10];
      level[10] = 1'b0; wait_n(3); level[10] = 1'b1; wait_n(8);
      chk(dlv_n == d0 + 1, "R3 blocked while in service", dlv_n, d0 + 1);
      chk(coal_cnt[10] == c0 + 1, "R4 level re-assert coalesced", coal_cnt[10], c0 + 1);
      a0 = ack_n;
      send_eoi(8'h40, 1'b0); wait_n(8);
      chk(ack_n == a0 + 1 && ack_log[a0] == 10, "R6 edge-type EOI acknowledged", ack_n, a0 + 1);
      chk(dlv_n == d0 + 1, "R7 edge-type EOI does not release", dlv_n, d0 + 1);
      send_eoi(8'h40, 1'b1); wait_n(8);
      chk(dlv_n == d0 + 2 && dlv_log[d0+1] == 10, "R7 level EOI re-services held pin", dlv_n, d0 + 2);
      mask[10] = 1'b1;
      send_eoi(8'h40, 1'b1); wait_n(8);
      chk(dlv_n == d0 + 2, "R5 masked pin not re-serviced after EOI", dlv_n, d0 + 2);
      chk(ack_n == a0 + 3, "R6 each EOI acknowledged", ack_n, a0 + 3);
      mask[10] = 1'b0; level[10] = 1'b0; wait_n(3); level[10] = 1'b1; wait_n(8);
      chk(dlv_n == d0 + 3, "R3 delivered again once flag released", dlv_n, d0 + 3);
      rewrite[10] = 1'b1; wait_n(1); rewrite[10] = 1'b0; wait_n(8);
      chk(dlv_n == d0 + 4 && dlv_log[d0+3] == 10, "R8 rewrite re-services held pin", dlv_n, d0 + 4);
      level[10] = 1'b0; wait_n(3); trig[10] = 1'b0; vec[10] = VW'(8'h2A); wait_n(2);

      // R6 shared vector, several pins
      vec[2] = 8'h77; vec[11] = 8'h77; vec[20] = 8'h77; wait_n(1);
      a0 = ack_n; d0 = dlv_n;
      send_eoi(8'h77, 1'b1); wait_n(8);
      chk(ack_n == a0 + 3, "R6 all matching pins acknowledged", ack_n, a0 + 3);
      chk(ack_log[a0] == 2 && ack_log[a0+1] == 11 && ack_log[a0+2] == 20,
          "R6 ascending acknowledge order", ack_log[a0+1], 11);
      chk(ack_cyc[a0+1] == ack_cyc[a0] + 1 && ack_cyc[a0+2] == ack_cyc[a0] + 2,
          "R6 acknowledges in consecutive cycles", ack_cyc[a0+2] - ack_cyc[a0], 2);
      chk(dlv_n == d0, "R7 EOI on edge pins delivers nothing", dlv_n, d0);

      finish_up();
   end
endmodule